// File: doc/BRIEF.md
# Memory Request Qualifier

This block screens each memory request before it reaches address translation. From the virtual address, the access kind (instruction fetch, data read or data write), a handful of per-request flags and a set of system control bits, it decides in one pass whether the request is an exclusive-monitor clear, whether it breaks alignment rules, whether it can bypass translation, and whether it must be treated as uncacheable. Table walking and the translation cache sit downstream and are not part of this block.

A request is presented for one cycle with `req_valid`. One cycle later `rsp_done` pulses for one cycle and the registered result appears on the response outputs. The result then holds until the next request. When translation is off, the block returns the physical address directly. When translation is on and nothing faults, it raises `rsp_needs_xlate` so the caller can hand the request on to the translation stage.

Top module: `rqc_top`

## Requirements
- R1: A request with `req_clr_excl` set completes with `rsp_fault_align`=0, `rsp_paddr`=0, `rsp_pa_valid`=1, `rsp_uncacheable`=1, `rsp_clr_excl`=1, `rsp_shareable`=0 and `rsp_needs_xlate`=0.
- R2: The clear-exclusive result of R1 takes priority over the alignment check, the translation enable and every cacheability input.
- R3: For a fetch (`req_kind`=2'b10) with no clear-exclusive flag, `rsp_uncacheable` is 1 whenever `ctl_icache_en` is 0, and `ctl_dcache_en` has no effect on it.
- R4: For a data access (`req_kind` 2'b00 read, 2'b01 write, 2'b11 treated as a read) with no clear-exclusive flag, `rsp_uncacheable` is 1 whenever `ctl_dcache_en` is 0, and `ctl_icache_en` has no effect on it.
- R5: A data access faults (`rsp_fault_align`=1, `rsp_pa_valid`=0, `rsp_needs_xlate`=0, `rsp_paddr`=0, `rsp_shareable`=0) when (`ctl_strict_align`=1 or `req_allow_unaligned`=0) and the low MASK_W address bits ANDed with `req_align_mask` are nonzero. `rsp_uncacheable` still follows R3/R4.
- R6: A fetch never raises `rsp_fault_align`.
- R7: With `ctl_xlate_en`=0 and no fault or clear-exclusive flag, `rsp_paddr` equals `req_vaddr`, and `rsp_pa_valid`=1, `rsp_shareable`=1, `rsp_needs_xlate`=0.
- R8: With `ctl_xlate_en`=0 and `ctl_remap_en`=0, a non-faulting, non-clearing request has `rsp_uncacheable`=1.
- R9: With `ctl_xlate_en`=0 and `ctl_remap_en`=1, a non-faulting, non-clearing request is uncacheable if `ctl_inner_attr0`=0, `ctl_outer_attr0`=0 or `ctl_mem_type0`≠2. Otherwise the R3/R4 cache-enable result applies.
- R10: With `ctl_xlate_en`=1 and no fault or clear-exclusive flag, `rsp_needs_xlate`=1, `rsp_pa_valid`=0, `rsp_paddr`=0, `rsp_shareable`=0, and `rsp_uncacheable` follows R3/R4.
- R11: `rsp_done` is 1 exactly in the cycle after a cycle with `req_valid`=1. The response outputs keep their values while no request arrives, and after reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_vaddr | input | ADDR_W | Virtual address |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 treated as read |
| req_clr_excl | input | 1 | Exclusive-monitor clear request |
| req_allow_unaligned | input | 1 | Request tolerates misalignment |
| req_align_mask | input | MASK_W | Address bits that must be zero for alignment |
| ctl_xlate_en | input | 1 | Translation enabled |
| ctl_icache_en | input | 1 | Instruction cache enabled |
| ctl_dcache_en | input | 1 | Data cache enabled |
| ctl_strict_align | input | 1 | Force alignment checking |
| ctl_remap_en | input | 1 | Attribute remap enabled |
| ctl_inner_attr0 | input | ATTR_W | Remap inner attribute, entry 0 |
| ctl_outer_attr0 | input | ATTR_W | Remap outer attribute, entry 0 |
| ctl_mem_type0 | input | ATTR_W | Remap memory type, entry 0 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fault_align | output | 1 | Alignment fault |
| rsp_uncacheable | output | 1 | Request must not be cached |
| rsp_clr_excl | output | 1 | Request was an exclusive clear |
| rsp_shareable | output | 1 | Bypass access treated as shareable |
| rsp_pa_valid | output | 1 | rsp_paddr holds a final physical address |
| rsp_needs_xlate | output | 1 | Forward to translation stage |
| rsp_paddr | output | ADDR_W | Physical address |

## Verification
The hardest case to reach is a translation-off request that ends up cacheable. It needs remap enabled, both attribute-0 fields nonzero, a memory type of exactly 2, the matching cache enable set and an address that passes the alignment check, all at once. Uniform random values would seldom line up like this. For that reason, half of the random requests force the remap fields to their passing values and a quarter force the alignment mask to zero. Directed cases then cover each single field that flips the result on its own. Clear-exclusive requests are also combined with misaligned addresses and with translation both on and off, to show that the clear takes priority.

// File: rtl/rqc_pkg.sv
package rqc_pkg;

    typedef enum logic [1:0] {
        KIND_READ  = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_FETCH = 2'b10,
        KIND_RSVD  = 2'b11
    } acc_kind_e;

    localparam int ATTR_W = 2;
    localparam logic [ATTR_W-1:0] MEMTYPE_CACHEABLE = 2'd2;

    typedef struct packed {
        logic fault_align;
        logic uncacheable;
        logic clr_excl;
        logic shareable;
        logic pa_valid;
        logic needs_xlate;
    } rsp_flags_t;

    function automatic logic kind_is_fetch(input acc_kind_e k);
        return k == KIND_FETCH;
    endfunction

    function automatic logic remap_blocks_cache(
        input logic              remap_en,
        input logic [ATTR_W-1:0] inner0,
        input logic [ATTR_W-1:0] outer0,
        input logic [ATTR_W-1:0] type0
    );
        if (!remap_en)
            return 1'b1;
        return (inner0 == '0) || (outer0 == '0) || (type0 != MEMTYPE_CACHEABLE);
    endfunction

endpackage

// File: rtl/rqc_align.sv
module rqc_align
    import rqc_pkg::*;
#(
    parameter int MASK_W = 6
) (
    input  logic [MASK_W-1:0] addr_low,
    input  acc_kind_e         kind,
    input  logic              allow_unaligned,
    input  logic              strict_align,
    input  logic [MASK_W-1:0] align_mask,
    output logic              fault
);
    logic check_on;
    logic overlap;

    always_comb begin
        check_on = !kind_is_fetch(kind) && (strict_align || !allow_unaligned);
        overlap  = |(addr_low & align_mask);
        fault    = check_on && overlap;
    end
endmodule

// File: rtl/rqc_cacheability.sv
module rqc_cacheability
    import rqc_pkg::*;
(
    input  acc_kind_e         kind,
    input  logic              icache_en,
    input  logic              dcache_en,
    input  logic              remap_en,
    input  logic [ATTR_W-1:0] inner0,
    input  logic [ATTR_W-1:0] outer0,
    input  logic [ATTR_W-1:0] type0,
    output logic              uc_cache,
    output logic              uc_bypass
);
    always_comb begin
        uc_cache  = kind_is_fetch(kind) ? !icache_en : !dcache_en;
        uc_bypass = uc_cache || remap_blocks_cache(remap_en, inner0, outer0, type0);
    end
endmodule

// File: rtl/rqc_top.sv
module rqc_top
    import rqc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic              req_clr_excl,
    input  logic              req_allow_unaligned,
    input  logic [MASK_W-1:0] req_align_mask,
    input  logic              ctl_xlate_en,
    input  logic              ctl_icache_en,
    input  logic              ctl_dcache_en,
    input  logic              ctl_strict_align,
    input  logic              ctl_remap_en,
    input  logic [ATTR_W-1:0] ctl_inner_attr0,
    input  logic [ATTR_W-1:0] ctl_outer_attr0,
    input  logic [ATTR_W-1:0] ctl_mem_type0,
    output logic              rsp_done,
    output logic              rsp_fault_align,
    output logic              rsp_uncacheable,
    output logic              rsp_clr_excl,
    output logic              rsp_shareable,
    output logic              rsp_pa_valid,
    output logic              rsp_needs_xlate,
    output logic [ADDR_W-1:0] rsp_paddr
);
    localparam int LOW_W = (MASK_W < ADDR_W) ? MASK_W : ADDR_W;

    acc_kind_e   kind;
    logic        align_fault;
    logic        uc_cache;
    logic        uc_bypass;
    rsp_flags_t  nxt_flags;
    rsp_flags_t  cur_flags;
    logic [ADDR_W-1:0] nxt_pa;
    logic [ADDR_W-1:0] cur_pa;
    logic        done_q;
    logic [MASK_W-1:0] addr_low;

    assign kind = acc_kind_e'(req_kind);

    always_comb begin
        addr_low = '0;
        addr_low[LOW_W-1:0] = req_vaddr[LOW_W-1:0];
    end

    rqc_align #(.MASK_W(MASK_W)) u_align (
        .addr_low        (addr_low),
        .kind            (kind),
        .allow_unaligned (req_allow_unaligned),
        .strict_align    (ctl_strict_align),
        .align_mask      (req_align_mask),
        .fault           (align_fault)
    );

    rqc_cacheability u_cache (
        .kind      (kind),
        .icache_en (ctl_icache_en),
        .dcache_en (ctl_dcache_en),
        .remap_en  (ctl_remap_en),
        .inner0    (ctl_inner_attr0),
        .outer0    (ctl_outer_attr0),
        .type0     (ctl_mem_type0),
        .uc_cache  (uc_cache),
        .uc_bypass (uc_bypass)
    );

    // Priority: exclusive clear, then alignment, then bypass or forward.
    always_comb begin
        nxt_flags = '0;
        nxt_pa    = '0;
        if (req_clr_excl) begin
            nxt_flags.uncacheable = 1'b1;
            nxt_flags.clr_excl    = 1'b1;
            nxt_flags.pa_valid    = 1'b1;
        end else begin
            nxt_flags.uncacheable = uc_cache;
            if (align_fault) begin
                nxt_flags.fault_align = 1'b1;
            end else if (!ctl_xlate_en) begin
                nxt_flags.uncacheable = uc_bypass;
                nxt_flags.pa_valid    = 1'b1;
                nxt_flags.shareable   = 1'b1;
                nxt_pa                = req_vaddr;
            end else begin
                nxt_flags.needs_xlate = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q    <= 1'b0;
            cur_flags <= '0;
            cur_pa    <= '0;
        end else begin
            done_q <= req_valid;
            if (req_valid) begin
                cur_flags <= nxt_flags;
                cur_pa    <= nxt_pa;
            end
        end
    end

    assign rsp_done        = done_q;
    assign rsp_fault_align = cur_flags.fault_align;
    assign rsp_uncacheable = cur_flags.uncacheable;
    assign rsp_clr_excl    = cur_flags.clr_excl;
    assign rsp_shareable   = cur_flags.shareable;
    assign rsp_pa_valid    = cur_flags.pa_valid;
    assign rsp_needs_xlate = cur_flags.needs_xlate;
    assign rsp_paddr       = cur_pa;
endmodule

// File: rtl/rqc_checker.sv
module rqc_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic [1:0]        req_kind,
    input logic              req_clr_excl,
    input logic              rsp_done,
    input logic              rsp_fault_align,
    input logic              rsp_uncacheable,
    input logic              rsp_clr_excl,
    input logic              rsp_shareable,
    input logic              rsp_pa_valid,
    input logic              rsp_needs_xlate,
    input logic [ADDR_W-1:0] rsp_paddr
);
    // R1 / R2
    a_r1_clear_result: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_clr_excl |=> rsp_clr_excl && rsp_uncacheable && rsp_pa_valid
                                      && !rsp_fault_align && rsp_paddr == '0);

    // R5
    a_r5_fault_blocks_forward: assert property (@(posedge clk) disable iff (rst)
        rsp_fault_align |-> !rsp_pa_valid && !rsp_needs_xlate && !rsp_clr_excl);

    // R6
    a_r6_fetch_no_fault: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_kind == 2'b10 |=> !rsp_fault_align);

    // R7
    a_r7_bypass_address: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_clr_excl |=> !rsp_pa_valid || (rsp_paddr == $past(req_vaddr) && rsp_shareable));

    // R10
    a_r10_forward_exclusive: assert property (@(posedge clk) disable iff (rst)
        rsp_needs_xlate |-> !rsp_pa_valid && rsp_paddr == '0);

    // R11
    a_r11_done_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_done);
    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_done);
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(rsp_paddr) && $stable(rsp_uncacheable) && $stable(rsp_pa_valid));
endmodule

bind rqc_top rqc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .req_vaddr       (req_vaddr),
    .req_kind        (req_kind),
    .req_clr_excl    (req_clr_excl),
    .rsp_done        (rsp_done),
    .rsp_fault_align (rsp_fault_align),
    .rsp_uncacheable (rsp_uncacheable),
    .rsp_clr_excl    (rsp_clr_excl),
    .rsp_shareable   (rsp_shareable),
    .rsp_pa_valid    (rsp_pa_valid),
    .rsp_needs_xlate (rsp_needs_xlate),
    .rsp_paddr       (rsp_paddr)
);

// File: tb/sim_rqc_top.sv
`timescale 1ns/1ps
module sim_rqc_top;
    localparam int AW = 32;
    localparam int MW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_vaddr = '0;
    logic [1:0] req_kind = '0;
    logic req_clr_excl = 1'b0, req_allow_unaligned = 1'b0;
    logic [MW-1:0] req_align_mask = '0;
    logic ctl_xlate_en = 1'b0, ctl_icache_en = 1'b0, ctl_dcache_en = 1'b0;
    logic ctl_strict_align = 1'b0, ctl_remap_en = 1'b0;
    logic [1:0] ctl_inner_attr0 = '0, ctl_outer_attr0 = '0, ctl_mem_type0 = '0;
    logic rsp_done, rsp_fault_align, rsp_uncacheable, rsp_clr_excl;
    logic rsp_shareable, rsp_pa_valid, rsp_needs_xlate;
    logic [AW-1:0] rsp_paddr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rqc_top #(.ADDR_W(AW), .MASK_W(MW)) u0 (.*);

    // Packed as {fault, uc, clr, share, pa_valid, xlate, paddr}
    function automatic logic [AW+5:0] model();
        logic fetch, uc_c, flt, remap_uc;
        fetch = (req_kind == 2'b10);
        if (req_clr_excl) return {6'b011010, {AW{1'b0}}};
        uc_c = fetch ? !ctl_icache_en : !ctl_dcache_en;
        flt  = !fetch && (ctl_strict_align || !req_allow_unaligned)
               && ((req_vaddr[MW-1:0] & req_align_mask) != 0);
        if (flt) return {1'b1, uc_c, 4'b0000, {AW{1'b0}}};
        if (!ctl_xlate_en) begin
            remap_uc = !ctl_remap_en || ctl_inner_attr0 == 0 || ctl_outer_attr0 == 0
                       || ctl_mem_type0 != 2'd2;
            return {1'b0, uc_c | remap_uc, 4'b0110, req_vaddr};
        end
        return {1'b0, uc_c, 4'b0001, {AW{1'b0}}};
    endfunction

    function automatic string tag_of();
        if (req_clr_excl) return "R1";
        if (req_kind != 2'b10 && (ctl_strict_align || !req_allow_unaligned)
            && ((req_vaddr[MW-1:0] & req_align_mask) != 0)) return "R5";
        if (!ctl_xlate_en) return ctl_remap_en ? "R9" : "R8";
        return (req_kind == 2'b10) ? "R3" : "R4";
    endfunction

    function automatic logic [AW+5:0] actual();
        return {rsp_fault_align, rsp_uncacheable, rsp_clr_excl, rsp_shareable,
                rsp_pa_valid, rsp_needs_xlate, rsp_paddr};
    endfunction

    task automatic check(input string tag, input logic [AW+5:0] act, input logic [AW+5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at negedge, check at the negedge after the capturing edge.
    task automatic issue(input string tag);
        logic [AW+5:0] exp;
        exp = model();
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " result"}, actual(), exp);
        check("R11 done", {{(AW+5){1'b0}}, rsp_done}, {{(AW+5){1'b0}}, 1'b1});
        req_clr_excl = ~req_clr_excl;
        ctl_xlate_en = ~ctl_xlate_en;
        req_vaddr = ~req_vaddr;
        @(negedge clk);
        check("R11 hold", actual(), exp);
        check("R11 single", {{(AW+5){1'b0}}, rsp_done}, '0);
        req_clr_excl = ~req_clr_excl;
        ctl_xlate_en = ~ctl_xlate_en;
        req_vaddr = ~req_vaddr;
    endtask

    task automatic setup(input logic [1:0] k, input logic [AW-1:0] va, input logic [MW-1:0] m,
                         input logic clr, input logic allow, input logic strict, input logic xl,
                         input logic ic, input logic dc, input logic rm,
                         input logic [1:0] in0, input logic [1:0] out0, input logic [1:0] ty0);
        req_kind = k; req_vaddr = va; req_align_mask = m; req_clr_excl = clr;
        req_allow_unaligned = allow; ctl_strict_align = strict; ctl_xlate_en = xl;
        ctl_icache_en = ic; ctl_dcache_en = dc; ctl_remap_en = rm;
        ctl_inner_attr0 = in0; ctl_outer_attr0 = out0; ctl_mem_type0 = ty0;
    endtask

    initial begin
        #(5 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R11 reset", {actual()[AW+5:0]}, '0);
        check("R11 reset done", {{(AW+5){1'b0}}, rsp_done}, '0);
        @(negedge clk);

        // R1 / R2: clear wins over misalignment and translation enabled
        setup(2'b01, 32'h0000_0013, 6'h03, 1, 0, 1, 1, 1, 1, 1, 1, 1, 2); issue("R2");
        setup(2'b00, 32'hABCD_0007, 6'h07, 1, 0, 1, 0, 1, 1, 0, 0, 0, 0); issue("R1");
        // R3: fetch, icache off, dcache on, translation on
        setup(2'b10, 32'h0000_1003, 6'h3F, 0, 0, 1, 1, 0, 1, 0, 0, 0, 0); issue("R3");
        // R6: fetch with misaligned address and mask, icache on -> cacheable, forward
        setup(2'b10, 32'h0000_1007, 6'h07, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0); issue("R6");
        // R4: write, dcache off, icache on
        setup(2'b01, 32'h0000_2000, 6'h03, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0); issue("R4");
        // R5: strict off, unaligned not allowed -> fault
        setup(2'b00, 32'h0000_2002, 6'h03, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0); issue("R5");
        // R5: unaligned allowed, strict off -> no fault
        setup(2'b00, 32'h0000_2002, 6'h03, 0, 1, 0, 1, 1, 1, 0, 0, 0, 0); issue("R5");
        // R5: reserved kind as read, strict on
        setup(2'b11, 32'h0000_2001, 6'h01, 0, 1, 1, 0, 1, 1, 1, 1, 1, 2); issue("R5");
        // R7 / R8: bypass, remap off
        setup(2'b00, 32'h8765_4320, 6'h0F, 0, 0, 1, 0, 1, 1, 0, 1, 1, 2); issue("R8");
        // R9: remap passing -> cacheable
        setup(2'b00, 32'h1234_5678, 6'h00, 0, 0, 1, 0, 1, 1, 1, 1, 1, 2); issue("R9");
        setup(2'b00, 32'h1234_5678, 6'h00, 0, 0, 1, 0, 1, 1, 1, 0, 1, 2); issue("R9");
        setup(2'b00, 32'h1234_5678, 6'h00, 0, 0, 1, 0, 1, 1, 1, 1, 0, 2); issue("R9");
        setup(2'b00, 32'h1234_5678, 6'h00, 0, 0, 1, 0, 1, 1, 1, 1, 1, 3); issue("R9");
        setup(2'b10, 32'h1234_5678, 6'h00, 0, 0, 1, 0, 0, 1, 1, 1, 1, 2); issue("R9");
        // R7: bypass address check with full range
        setup(2'b10, 32'hFFFF_FFFF, 6'h3F, 0, 0, 1, 0, 1, 1, 1, 3, 3, 2); issue("R7");
        // R10: translation on, data access
        setup(2'b01, 32'h4000_0040, 6'h07, 0, 0, 1, 1, 1, 1, 1, 1, 1, 2); issue("R10");

        for (int i = 0; i < 400; i++) begin
            req_kind = 2'($urandom_range(0, 3));
            req_vaddr = $urandom();
            req_align_mask = ($urandom_range(0, 3) == 0) ? '0 : MW'($urandom());
            req_clr_excl = ($urandom_range(0, 7) == 0);
            req_allow_unaligned = 1'($urandom());
            ctl_strict_align = 1'($urandom());
            ctl_xlate_en = 1'($urandom());
            ctl_icache_en = 1'($urandom());
            ctl_dcache_en = 1'($urandom());
            ctl_remap_en = 1'($urandom());
            if ($urandom_range(0, 1) == 0) begin
                ctl_inner_attr0 = 2'($urandom_range(1, 3));
                ctl_outer_attr0 = 2'($urandom_range(1, 3));
                ctl_mem_type0 = 2'd2;
            end else begin
                ctl_inner_attr0 = 2'($urandom());
                ctl_outer_attr0 = 2'($urandom());
                ctl_mem_type0 = 2'($urandom());
            end
            issue(tag_of());
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule